// File: doc/BRIEF.md
# Biquad Coefficient RAM Controller

This block owns the coefficient storage for a cascade of second-order IIR sections. Each section uses five coefficients (b0, b1, b2, a1, a2). Each coefficient is a 19-bit two's-complement fixed-point value with 3 integer bits and 16 fraction bits. The storage is addressed as `section*5 + index`, where index 0..4 selects b0, b1, b2, a1, a2 in that order. The filter datapath reads any entry through a combinational read port.

The block stays idle while its enable input `load_go` is low. When `load_go` goes high, the block starts a fixed-length loading window. In that window it writes a built-in low-pass coefficient set into storage, one entry per clock, and then waits for the rest of the window. After the window, a processor may overwrite entries through a simple address/data/strobe port. It may do so only while coefficient programming is allowed and the filter is not running. Processor strobes that arrive during the window are dropped.

The controller is a four-state machine:
- `ST_IDLE`: held off.
- `ST_LOAD`: writing defaults.
- `ST_DRAIN`: the idle tail of the window.
- `ST_READY`: processor access open.

Transitions:
- IDLE→LOAD when `load_go` is seen high.
- LOAD→DRAIN after the last default entry.
- DRAIN→READY when the window count reaches its end.
- Any state→IDLE when `load_go` is seen low.

Top module: `biq_coef_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are low. They stay low for as long as `load_go` is held low.
- R2: The window starts at the first clock edge that sees `load_go` high. From then on, `busy` is high for exactly 32 cycles, and then `done` goes high. `busy` and `done` are never high together.
- R3: During the window, every one of the 30 entries is loaded with its default. The defaults are the same for all six sections: b0 = 0x01000, b1 = 0x02000, b2 = 0x01000, a1 = 0x68000 (-1.5), a2 = 0x09000 (0.5625).
- R4: A processor write strobe is ignored while `done` is low, including strobes made during the window.
- R5: While `done` is high, a strobe with `prog_en` high and `filt_en` low writes `wr_data` to entry `wr_addr`. The new value is readable on `rd_data` in the next cycle.
- R6: A strobe made while `prog_en` is low, or while `filt_en` is high, leaves the addressed entry unchanged.
- R7: A write to an address of 30 or above changes no entry. A read from such an address returns 0.
- R8: `done` stays high while `load_go` stays high. It falls one cycle after `load_go` is seen low. Raising `load_go` again runs a fresh window, and that window restores the defaults.
- R9: `rd_data` follows `rd_addr` combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_go | input | 1 | High: run the loading window and then stay active. Low: hold idle |
| prog_en | input | 1 | Allows processor coefficient writes |
| filt_en | input | 1 | Filter running; blocks processor writes |
| wr_stb | input | 1 | Processor write strobe |
| wr_addr | input | 5 | Processor write entry address |
| wr_data | input | 19 | Processor write value (3.16 format) |
| rd_addr | input | 5 | Datapath read entry address |
| rd_data | output | 19 | Datapath read value |
| busy | output | 1 | Loading window in progress |
| done | output | 1 | Window finished; processor access open |

## Verification
The bench counts the window to the exact cycle. A design that ends the window after the last default write, rather than after the full 32 cycles, opens processor access too early and shows up as a count of 30.

The bench fires strobes during the window at an entry that the loader has already written. A design that leaks these strobes leaves the strobe value in place of the default.

The bench sweeps all 30 entries twice:
- once for the defaults;
- once with a per-address pattern, to catch address-mapping slips.

It also probes each write-gating input on its own, and writes to addresses 30 and 31. Finally it drops and re-raises `load_go` over programmed values. A controller that skips the reload keeps the old pattern instead of the defaults.

// File: rtl/biq_coef_pkg.sv
package biq_coef_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_READY = 2'd3
    } ld_state_e;

    // Built-in low-pass set, identical for each section (3.16, 19 bits)
    function automatic logic [18:0] coef_default(input logic [2:0] idx);
        logic [18:0] v;
        unique case (idx)
            3'd0:    v = 19'h01000;   // b0 = 0.0625
            3'd1:    v = 19'h02000;   // b1 = 0.125
            3'd2:    v = 19'h01000;   // b2 = 0.0625
            3'd3:    v = 19'h68000;   // a1 = -1.5
            3'd4:    v = 19'h09000;   // a2 = 0.5625
            default: v = 19'h00000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/biq_coef_seq.sv
module biq_coef_seq
    import biq_coef_pkg::*;
#(
    parameter int N_SEC  = 6,
    parameter int N_COEF = 5,
    parameter int WIN    = 32,
    parameter int CW     = 19,
    localparam int DEPTH = N_SEC * N_COEF,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    output logic          ld_we,
    output logic [AW-1:0] ld_addr,
    output logic [CW-1:0] ld_data,
    output logic          busy,
    output logic          done
);

    ld_state_e       st_q, st_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [2:0]      idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            idx_q <= idx_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        idx_d = idx_q;
        if (!load_go) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            idx_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_LOAD;
                    cnt_d = '0;
                    idx_d = '0;
                end
                ST_LOAD: begin
                    cnt_d = cnt_q + 1'b1;
                    idx_d = (idx_q == 3'(N_COEF - 1)) ? 3'd0 : idx_q + 3'd1;
                    if (cnt_q == CNTW'(WIN - 1))
                        st_d = ST_READY;
                    else if (cnt_q == CNTW'(DEPTH - 1))
                        st_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNTW'(WIN - 1))
                        st_d = ST_READY;
                end
                ST_READY: st_d = ST_READY;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_we   = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        ld_addr = AW'(cnt_q);
        ld_data = CW'(coef_default(idx_q));
        unique case (st_q)
            ST_IDLE:  ;
            ST_LOAD:  begin busy = 1'b1; ld_we = 1'b1; end
            ST_DRAIN: busy = 1'b1;
            ST_READY: done = 1'b1;
            default:  ;
        endcase
    end

    // R3: loader only addresses real entries
    a_r3_load_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> (ld_addr < AW'(DEPTH)));

    // R8: done held while load_go held
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && load_go) |=> done);

    // R2: done only follows the window
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: rtl/biq_coef_mem.sv
module biq_coef_mem #(
    parameter int DEPTH = 30,
    parameter int CW    = 19,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rdata
);

    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH)))
            mem[waddr] <= wdata;
    end

    // R7/R9: combinational read, zero outside the array
    always_comb begin
        if (raddr < AW'(DEPTH))
            rdata = mem[raddr];
        else
            rdata = '0;
    end

endmodule

// File: rtl/biq_coef_ctrl.sv
module biq_coef_ctrl #(
    parameter int N_SEC  = 6,
    parameter int N_COEF = 5,
    parameter int WIN    = 32,
    parameter int CW     = 19,
    localparam int DEPTH = N_SEC * N_COEF,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    input  logic          prog_en,
    input  logic          filt_en,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          busy,
    output logic          done
);

    logic          ld_we;
    logic [AW-1:0] ld_addr;
    logic [CW-1:0] ld_data;
    logic          cpu_we;
    logic          m_we;
    logic [AW-1:0] m_addr;
    logic [CW-1:0] m_data;

    biq_coef_seq #(
        .N_SEC (N_SEC),
        .N_COEF(N_COEF),
        .WIN   (WIN),
        .CW    (CW)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_go(load_go),
        .ld_we  (ld_we),
        .ld_addr(ld_addr),
        .ld_data(ld_data),
        .busy   (busy),
        .done   (done)
    );

    // processor write gate
    assign cpu_we = wr_stb && done && prog_en && !filt_en;

    // loader owns the port while it is writing
    always_comb begin
        if (ld_we) begin
            m_we   = 1'b1;
            m_addr = ld_addr;
            m_data = ld_data;
        end else begin
            m_we   = cpu_we;
            m_addr = wr_addr;
            m_data = wr_data;
        end
    end

    biq_coef_mem #(
        .DEPTH(DEPTH),
        .CW   (CW)
    ) u_mem (
        .clk  (clk),
        .we   (m_we),
        .waddr(m_addr),
        .wdata(m_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    // window length monitor
    localparam int LW = $clog2(WIN) + 2;
    logic [LW-1:0] busy_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R2: full window length before done
    a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && done) |-> (busy_len == LW'(WIN)));

    // R2: busy and done exclusive
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: processor never writes during the window
    a_r4_no_cpu_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_we);

    // R6: gated writes require programming permission and a stopped filter
    a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |-> (prog_en && !filt_en));

endmodule

// File: tb/biq_coef_ctrl_test.sv
module biq_coef_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_go = 1'b0;
    logic        prog_en = 1'b0;
    logic        filt_en = 1'b0;
    logic        wr_stb = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [18:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [18:0] rd_data;
    logic        busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    biq_coef_ctrl uut (
        .clk(clk), .rst_n(rst_n), .load_go(load_go), .prog_en(prog_en),
        .filt_en(filt_en), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    function automatic logic [18:0] dflt(input int a);
        int k;
        k = a % 5;
        if (k == 0 || k == 2) return 19'd4096;
        if (k == 1)           return 19'd8192;
        if (k == 3)           return 19'(524288 - 98304);
        return 19'd36864;
    endfunction

    function automatic logic [18:0] pat(input int a);
        return 19'((a * 9157 + 333) % 524288);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [18:0] v);
        rd_addr = 5'(a);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [18:0] d);
        @(negedge clk);
        wr_addr = 5'(a); wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic run_window(output int len);
        @(negedge clk);
        load_go = 1'b1;
        len = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (busy) len++;
            if (done) break;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [18:0] v;
        int len;
        int bad_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        repeat (10) @(negedge clk);
        chk("R1 idle busy", busy, 0);
        chk("R1 idle done", done, 0);

        // R2 / R4: window with strobes during it at entry 0
        @(negedge clk);
        load_go = 1'b1; prog_en = 1'b1;
        len = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (busy) begin
                len++;
                if (len >= 4) begin
                    wr_addr = 5'd0; wr_data = 19'h7abcd; wr_stb = 1'b1;
                end
                chk("R2 exclusive", {busy, done} == 2'b11, 0);
            end
            if (done) break;
        end
        wr_stb = 1'b0;
        chk("R2 window length", len, 32);
        chk("R2 done", done, 1);
        rd(0, v);
        chk("R4 window write lost", v, dflt(0));

        // R3: defaults, all entries
        bad_cnt = 0;
        for (int a = 0; a < 30; a++) begin
            rd(a, v);
            if (v !== dflt(a)) begin
                bad_cnt++;
                $display("FAIL R3 entry %0d: actual %0h expected %0h", a, v, dflt(a));
            end
        end
        n_chk++; if (bad_cnt != 0) n_bad++;

        // R9: combinational read
        rd(3, v);
        chk("R9 comb a1", v, dflt(3));
        rd(4, v);
        chk("R9 comb a2", v, dflt(4));

        // R5: program every entry
        for (int a = 0; a < 30; a++) wr(a, pat(a));
        bad_cnt = 0;
        for (int a = 0; a < 30; a++) begin
            rd(a, v);
            if (v !== pat(a)) begin
                bad_cnt++;
                $display("FAIL R5 entry %0d: actual %0h expected %0h", a, v, pat(a));
            end
        end
        n_chk++; if (bad_cnt != 0) n_bad++;

        // R6: prog_en low
        prog_en = 1'b0;
        wr(7, 19'h11111);
        rd(7, v);
        chk("R6 prog_en low", v, pat(7));
        // R6: filter running
        prog_en = 1'b1; filt_en = 1'b1;
        wr(8, 19'h22222);
        rd(8, v);
        chk("R6 filt_en high", v, pat(8));
        filt_en = 1'b0;

        // R7: out of range
        wr(30, 19'h33333);
        wr(31, 19'h44444);
        rd(30, v);
        chk("R7 read 30", v, 0);
        rd(31, v);
        chk("R7 read 31", v, 0);
        bad_cnt = 0;
        for (int a = 0; a < 30; a++) begin
            rd(a, v);
            if (v !== pat(a)) bad_cnt++;
        end
        chk("R7 no alias", bad_cnt, 0);

        // R8: drop and re-raise
        @(negedge clk);
        load_go = 1'b0;
        @(negedge clk);
        chk("R8 done falls", done, 0);
        chk("R8 busy low", busy, 0);
        wr(2, 19'h55555);
        rd(2, v);
        chk("R4 idle write lost", v, pat(2));
        run_window(len);
        chk("R8 second window", len, 32);
        bad_cnt = 0;
        for (int a = 0; a < 30; a++) begin
            rd(a, v);
            if (v !== dflt(a)) bad_cnt++;
        end
        chk("R8 defaults restored", bad_cnt, 0);
        repeat (5) @(negedge clk);
        chk("R8 done held", done, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule